// File: doc/BRIEF.md
# Bus Mode Detect and Switch Controller

This block is the digital controller of a dual-mode bus line terminator. Three synchronous comparator flags classify the sensed differential-sense level as single-ended (SE), low-voltage differential (LVD) or high-voltage differential (HVD). The block turns that reading into one committed bus mode. It also drives the enables for the SE switch set, the LVD switch set, the reference regulator and the sense-line driver, and two status outputs.

A reading must persist for a qualification delay of `DELAY_CYC` counted cycles before it becomes the committed mode. The same delay applies to every transition. The timer restarts whenever the candidate changes. An isolate request or an over-temperature flag overrides the switch outputs immediately and freezes the mode logic. When both are released, the committed mode drives the switches again.

The committed mode is held in a state machine with three states: `ST_SE` (the reset state), `ST_LVD` and `ST_HVD`. Each transition `ST_x -> ST_y` is taken only on a qualified commit of mode y. That gives six named transitions between distinct states. There is no other transition.

Top module: `busmode_ctrl`

## Requirements
- R1: After reset the committed mode is SE. The outputs are then se_sw_en=1, lvd_sw_en=0, isolated=0, vref_en=1, sense_drv_en=1, se_stat=1 and lvd_stat=0.
- R2: A valid reading is one flag of {cmp_hvd, cmp_lvd, cmp_se} high with the other two low. A valid reading that differs from the committed mode commits on the clock edge where it has been sampled for `DELAY_CYC` counted cycles. This holds for every transition between SE, LVD and HVD.
- R3: Two cases reset the count. A valid reading that differs from the current candidate becomes the new candidate with a count of one. A valid reading equal to the committed mode abandons the pending candidate and clears the count.
- R4: A gap reading, meaning no flag high or more than one flag high, leaves the candidate, the count and the committed mode unchanged.
- R5: With HVD committed, isolation is not requested and there is no over-temperature: both switch enables are 0, isolated=1, vref_en=0 and sense_drv_en=1.
- R6: While iso_req is high, isolated=1 and the switch enables, vref_en and sense_drv_en are 0 in the same cycle. The candidate, the count and the committed mode are frozen, and they resume when iso_req is released.
- R7: While over_temp is high, the outputs and the freezing behave exactly as in R6.
- R8: lvd_stat is 1 exactly when LVD is committed, and se_stat is 1 exactly when SE is committed. Neither depends on iso_req or over_temp.
- R9: In every cycle, exactly one of se_sw_en, lvd_sw_en and isolated is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_se | input | 1 | Sensed level is in the SE window |
| cmp_lvd | input | 1 | Sensed level is in the LVD window |
| cmp_hvd | input | 1 | Sensed level is in the HVD window |
| iso_req | input | 1 | Isolate request |
| over_temp | input | 1 | Over-temperature flag, with hysteresis applied upstream |
| se_sw_en | output | 1 | SE switch set enable |
| lvd_sw_en | output | 1 | LVD switch set enable |
| isolated | output | 1 | All switches in the disconnected position |
| vref_en | output | 1 | Reference regulator enable |
| sense_drv_en | output | 1 | Sense-line driver enable |
| lvd_stat | output | 1 | LVD committed |
| se_stat | output | 1 | SE committed |

## Verification
The checks take all inputs to be synchronous to clk and stable for a whole cycle. They also assume that a status change is always preceded by a cycle with a valid, unforced reading. The bench drives every input on the falling edge and samples on the next falling edge, so no input moves near a sampling edge. Gap patterns are covered in two forms: all flags low, and two flags high together. Each is held for whole cycles, so the assertion that a gap cycle leaves the committed mode unchanged sees a clean one-cycle history.

// File: rtl/busmode_pkg.sv
package busmode_pkg;

    typedef enum logic [1:0] {
        MODE_SE  = 2'd0,
        MODE_LVD = 2'd1,
        MODE_HVD = 2'd2
    } mode_t;

    typedef enum logic [1:0] {
        ST_SE  = 2'd0,
        ST_LVD = 2'd1,
        ST_HVD = 2'd2
    } state_t;

    function automatic mode_t state_to_mode(input state_t s);
        unique case (s)
            ST_LVD:  return MODE_LVD;
            ST_HVD:  return MODE_HVD;
            default: return MODE_SE;
        endcase
    endfunction

endpackage

// File: rtl/busmode_classify.sv
module busmode_classify
    import busmode_pkg::*;
(
    input  logic  flag_se,
    input  logic  flag_lvd,
    input  logic  flag_hvd,
    output logic  rd_valid,
    output mode_t rd_mode
);

    always_comb begin
        rd_valid = 1'b1;
        rd_mode  = MODE_SE;
        unique case ({flag_hvd, flag_lvd, flag_se})
            3'b001:  rd_mode = MODE_SE;
            3'b010:  rd_mode = MODE_LVD;
            3'b100:  rd_mode = MODE_HVD;
            default: rd_valid = 1'b0;   // gap: none or several windows
        endcase
    end

endmodule

// File: rtl/busmode_qualify.sv
module busmode_qualify
    import busmode_pkg::*;
#(
    parameter int DELAY_CYC = 125000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hold,
    input  logic  rd_valid,
    input  mode_t rd_mode,
    input  mode_t committed,
    output logic  commit_req,
    output mode_t commit_mode
);

    localparam int CW = $clog2(DELAY_CYC + 1);

    mode_t         cand_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt     = (rd_mode == cand_q) ? cnt_q + CW'(1) : CW'(1);
        commit_mode = rd_mode;
        commit_req  = !hold && rd_valid && (rd_mode != committed) &&
                      (cnt_nxt >= CW'(DELAY_CYC));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q <= MODE_SE;
            cnt_q  <= '0;
        end else if (!hold && rd_valid) begin
            cand_q <= rd_mode;
            if (rd_mode == committed || commit_req) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_nxt;
            end
        end
    end

endmodule

// File: rtl/busmode_ctrl.sv
module busmode_ctrl
    import busmode_pkg::*;
#(
    parameter int DELAY_CYC = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_se,
    input  logic cmp_lvd,
    input  logic cmp_hvd,
    input  logic iso_req,
    input  logic over_temp,
    output logic se_sw_en,
    output logic lvd_sw_en,
    output logic isolated,
    output logic vref_en,
    output logic sense_drv_en,
    output logic lvd_stat,
    output logic se_stat
);

    state_t state_q;
    state_t state_d;
    logic   forced;
    logic   rd_valid;
    mode_t  rd_mode;
    logic   commit_req;
    mode_t  commit_mode;

    assign forced = iso_req | over_temp;

    busmode_classify u_classify (
        .flag_se  (cmp_se),
        .flag_lvd (cmp_lvd),
        .flag_hvd (cmp_hvd),
        .rd_valid (rd_valid),
        .rd_mode  (rd_mode)
    );

    busmode_qualify #(.DELAY_CYC(DELAY_CYC)) u_qualify (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (forced),
        .rd_valid    (rd_valid),
        .rd_mode     (rd_mode),
        .committed   (state_to_mode(state_q)),
        .commit_req  (commit_req),
        .commit_mode (commit_mode)
    );

    always_comb begin
        state_d = state_q;
        if (commit_req) begin
            unique case (commit_mode)
                MODE_LVD: state_d = ST_LVD;
                MODE_HVD: state_d = ST_HVD;
                default:  state_d = ST_SE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        se_sw_en     = 1'b0;
        lvd_sw_en    = 1'b0;
        isolated     = 1'b1;
        vref_en      = 1'b0;
        sense_drv_en = !forced;
        lvd_stat     = 1'b0;
        se_stat      = 1'b0;
        unique case (state_q)
            ST_SE: begin
                se_stat  = 1'b1;
                se_sw_en = !forced;
                isolated = forced;
                vref_en  = !forced;
            end
            ST_LVD: begin
                lvd_stat  = 1'b1;
                lvd_sw_en = !forced;
                isolated  = forced;
                vref_en   = !forced;
            end
            default: begin
                isolated = 1'b1;
            end
        endcase
    end

endmodule

module busmode_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cmp_se,
    input logic cmp_lvd,
    input logic cmp_hvd,
    input logic iso_req,
    input logic over_temp,
    input logic se_sw_en,
    input logic lvd_sw_en,
    input logic isolated,
    input logic vref_en,
    input logic sense_drv_en,
    input logic lvd_stat,
    input logic se_stat
);

    logic gap;
    assign gap = ($countones({cmp_hvd, cmp_lvd, cmp_se}) != 1);

    a_r9_one_hot_switch: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({se_sw_en, lvd_sw_en, isolated}) == 1);

    a_r6_iso_disconnect: assert property (@(posedge clk) disable iff (!rst_n)
        iso_req |-> (isolated && !vref_en && !sense_drv_en && !se_sw_en && !lvd_sw_en));

    a_r7_ot_disconnect: assert property (@(posedge clk) disable iff (!rst_n)
        over_temp |-> (isolated && !vref_en && !sense_drv_en && !se_sw_en && !lvd_sw_en));

    a_r6_forced_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_req || over_temp) |=> $stable({lvd_stat, se_stat}));

    a_r4_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        gap |=> $stable({lvd_stat, se_stat}));

    a_r8_status_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(lvd_stat && se_stat));

    a_r5_hvd_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvd_stat && !se_stat && !iso_req && !over_temp) |->
            (isolated && !vref_en && sense_drv_en));

endmodule

bind busmode_ctrl busmode_ctrl_chk u_chk (.*);

// File: tb/busmode_ctrl_tb_top.sv
module busmode_ctrl_tb_top;

    localparam int D = 8;
    localparam int NV = 22;

    // outputs {se_sw, lvd_sw, isolated, vref, drv, lvd_stat, se_stat}
    localparam logic [6:0] O_SE  = 7'b1001101;
    localparam logic [6:0] O_LVD = 7'b0101110;
    localparam logic [6:0] O_HVD = 7'b0010100;
    localparam logic [6:0] F_SE  = 7'b0010001;
    localparam logic [6:0] F_LVD = 7'b0010010;
    localparam logic [6:0] F_HVD = 7'b0010000;

    // {flags{hvd,lvd,se}, iso, ot, cycles[7:0], expect[6:0], req[3:0]}
    localparam logic [23:0] VEC [NV] = '{
        {3'b001, 1'b0, 1'b0, 8'd4,  O_SE,  4'd1},  // R1
        {3'b010, 1'b0, 1'b0, 8'd7,  O_SE,  4'd2},  // R2 not yet
        {3'b010, 1'b0, 1'b0, 8'd1,  O_LVD, 4'd2},  // R2 commit
        {3'b001, 1'b0, 1'b0, 8'd5,  O_LVD, 4'd3},  // R3
        {3'b000, 1'b0, 1'b0, 8'd2,  O_LVD, 4'd4},  // R4 no flag
        {3'b011, 1'b0, 1'b0, 8'd1,  O_LVD, 4'd4},  // R4 two flags
        {3'b001, 1'b0, 1'b0, 8'd2,  O_LVD, 4'd4},  // R4 count kept
        {3'b001, 1'b0, 1'b0, 8'd1,  O_SE,  4'd2},  // R2
        {3'b010, 1'b0, 1'b0, 8'd5,  O_SE,  4'd3},  // R3
        {3'b100, 1'b0, 1'b0, 8'd7,  O_SE,  4'd3},  // R3 restart
        {3'b100, 1'b0, 1'b0, 8'd1,  O_HVD, 4'd5},  // R5
        {3'b001, 1'b1, 1'b0, 8'd10, F_HVD, 4'd6},  // R6 frozen
        {3'b001, 1'b0, 1'b0, 8'd7,  O_HVD, 4'd6},  // R6 resumes
        {3'b001, 1'b0, 1'b0, 8'd1,  O_SE,  4'd6},  // R6
        {3'b010, 1'b0, 1'b0, 8'd8,  O_LVD, 4'd2},  // R2
        {3'b010, 1'b0, 1'b1, 8'd1,  F_LVD, 4'd7},  // R7
        {3'b001, 1'b0, 1'b1, 8'd20, F_LVD, 4'd7},  // R7 frozen
        {3'b001, 1'b0, 1'b0, 8'd5,  O_LVD, 4'd7},  // R7
        {3'b010, 1'b0, 1'b0, 8'd1,  O_LVD, 4'd3},  // R3 abort
        {3'b001, 1'b0, 1'b0, 8'd7,  O_LVD, 4'd3},  // R3
        {3'b001, 1'b0, 1'b0, 8'd1,  O_SE,  4'd3},  // R3
        {3'b001, 1'b1, 1'b0, 8'd1,  F_SE,  4'd8}   // R8 status under iso
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_se = 1'b0, cmp_lvd = 1'b0, cmp_hvd = 1'b0;
    logic iso_req = 1'b0, over_temp = 1'b0;
    logic se_sw_en, lvd_sw_en, isolated, vref_en, sense_drv_en, lvd_stat, se_stat;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    busmode_ctrl #(.DELAY_CYC(D)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmp_se(cmp_se), .cmp_lvd(cmp_lvd), .cmp_hvd(cmp_hvd),
        .iso_req(iso_req), .over_temp(over_temp),
        .se_sw_en(se_sw_en), .lvd_sw_en(lvd_sw_en), .isolated(isolated),
        .vref_en(vref_en), .sense_drv_en(sense_drv_en),
        .lvd_stat(lvd_stat), .se_stat(se_stat)
    );

    function automatic logic [6:0] outs();
        return {se_sw_en, lvd_sw_en, isolated, vref_en, sense_drv_en, lvd_stat, se_stat};
    endfunction

    task automatic check(input logic [6:0] exp, input int req);
        n_chk++;
        if (outs() !== exp) begin
            n_fail++;
            $display("FAIL R%0d: outputs %b expected %b", req, outs(), exp);
        end
        n_chk++;
        if ($countones(outs()) == 0 || $countones(outs() & 7'b1110000) != 1) begin
            n_fail++;
            $display("FAIL R9: switch controls %b expected one hot", outs() & 7'b1110000);
        end
    endtask

    task automatic drive(input logic [2:0] f, input logic iso, input logic ot, input int cyc);
        {cmp_hvd, cmp_lvd, cmp_se} = f;
        iso_req = iso;
        over_temp = ot;
        repeat (cyc) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(O_SE, 1);                 // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        check(O_SE, 1);                 // R1 after release
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][23:21], VEC[i][20], VEC[i][19], int'(VEC[i][18:11]));
            check(VEC[i][10:4], int'(VEC[i][3:0]));
        end
        // R2: SE to HVD also takes the full delay
        drive(3'b100, 1'b0, 1'b0, D - 1);
        check(O_SE, 2);
        drive(3'b100, 1'b0, 1'b0, 1);
        check(O_HVD, 2);
        // R1: mid-run reset from LVD
        drive(3'b010, 1'b0, 1'b0, D);
        check(O_LVD, 2);
        rst_n = 1'b0;
        @(negedge clk);
        check(O_SE, 1);
        rst_n = 1'b1;
        drive(3'b001, 1'b0, 1'b0, 2);
        check(O_SE, 1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule